// File: doc/BRIEF.md
# Modem Control and Status Logic

This block sits beside a serial port. It holds the modem control byte and drives four active-low handshake outputs: data terminal ready, request to send and two general user outputs. It watches four active-low handshake inputs: clear to send, data set ready, ring indicator and carrier detect. Each input passes through a synchroniser. The block reports the inputs as active-high levels, together with sticky change flags, in a status byte. A read of the status byte clears the flags.

A host-side address decoder supplies a write strobe for the control byte and a read strobe for the status byte. The status byte is presented combinationally, so the cycle that carries the read strobe also returns the data. A loopback mode parks the output pins in their idle-high state and feeds the control bits into the status path in place of the pins. This lets software test the whole flag path without a cable. An interrupt request is raised while any change flag is set.

Top module: `modem_ctl_stat`

## Requirements
- R1: With control bit 4 clear, control bits 0, 1, 2 and 3 drive `dtr_n`, `rts_n`, `out1_n` and `out2_n` respectively. A 1 drives the pin low and a 0 drives it high. The pins change in the cycle after the write edge.
- R2: A write to the control byte stores bits 4:0. Bits 7:5 of the written data are discarded and always read back as 0 on `ctl_rdata`.
- R3: Status bits 7, 6, 5 and 4 give carrier detect, ring, data set ready and clear to send. Each is the complement of its input pin after a two-stage synchroniser. A pin change shows in the status byte after two rising edges.
- R4: Status bits 3, 1 and 0 are change flags for carrier detect, data set ready and clear to send. Each is set on any change of its level, one edge after the level changes. Each stays set until a status read.
- R5: Status bit 2 is set only when the ring input pin goes from low to high (the ring level falls). A high-to-low transition of the pin does not set it.
- R6: While `stat_rd` is high, `stat_rdata` shows the current levels and flags. The next edge clears all four flags, except for a flag whose change event falls in that same cycle, which is set.
- R7: With control bit 4 set, all four output pins are high and the external inputs are ignored. DTR feeds data set ready, RTS feeds clear to send, OUT1 feeds ring and OUT2 feeds carrier detect.
- R8: `irq` is high exactly when any of status bits 3:0 is set.
- R9: After reset the control byte is 0, all output pins are high and all change flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ctl_wr | input | 1 | Control byte write strobe from the decoder |
| ctl_wdata | input | 8 | Control byte write data |
| ctl_rdata | output | 8 | Control byte readback |
| stat_rd | input | 1 | Status byte read strobe from the decoder |
| stat_rdata | output | 8 | Status byte: levels in 7:4, change flags in 3:0 |
| cts_n | input | 1 | Clear to send, active low |
| dsr_n | input | 1 | Data set ready, active low |
| ri_n | input | 1 | Ring indicator, active low |
| dcd_n | input | 1 | Carrier detect, active low |
| dtr_n | output | 1 | Data terminal ready, active low |
| rts_n | output | 1 | Request to send, active low |
| out1_n | output | 1 | User output 1, active low |
| out2_n | output | 1 | User output 2, active low |
| irq | output | 1 | Modem status interrupt request |

## Verification
A status read and a new change event can land on the same clock edge, so the clear-on-read and the flag set compete for one register. The bench first leaves a clear-to-send flag pending. It then toggles the data-set-ready pin and counts two edges through the synchroniser, so that the change event is live during the cycle in which `stat_rd` is held. After that edge the status byte must hold only the data-set-ready flag: the old flag is cleared and the new one is kept. The same contention arises in loopback, where a control write moves the levels directly, and the loopback sweep interleaves reads with those writes.

// File: rtl/modem_pkg.sv
`timescale 1ns/1ps
package modem_pkg;

  localparam int MDM_LINES = 4;
  localparam int BYTE_W    = 8;
  localparam int CTL_W     = 5;

  // Stored control fields, bit 0 first from the LSB.
  typedef struct packed {
    logic loop;
    logic out2;
    logic out1;
    logic rts;
    logic dtr;
  } mdm_ctl_t;

  // Active-high line levels, ordered as in status bits 7:4.
  typedef struct packed {
    logic dcd;
    logic ri;
    logic dsr;
    logic cts;
  } mdm_lines_t;

  // Loopback routing of control bits onto the status levels.
  function automatic mdm_lines_t loop_map(input mdm_ctl_t c);
    mdm_lines_t l;
    l.dcd = c.out2;
    l.ri  = c.out1;
    l.dsr = c.dtr;
    l.cts = c.rts;
    return l;
  endfunction

endpackage

// File: rtl/modem_rst_sync.sv
`timescale 1ns/1ps
module modem_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_n_sync = chain_q[STAGES-1];

endmodule

// File: rtl/modem_sync_bank.sv
`timescale 1ns/1ps
module modem_sync_bank #(
  parameter int         WIDTH   = 4,
  parameter int         STAGES  = 2,
  parameter logic       RST_VAL = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);

  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    logic [WIDTH-1:0] stage_d;
    if (s == 0) begin : g_first
      always_comb stage_d = din;
    end else begin : g_rest
      always_comb stage_d = stage_q[s-1];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage_q[s] <= {WIDTH{RST_VAL}};
      else        stage_q[s] <= stage_d;
    end
  end

  assign dout = stage_q[STAGES-1];

endmodule

// File: rtl/modem_ctl_reg.sv
`timescale 1ns/1ps
module modem_ctl_reg
  import modem_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [CTL_W-1:0]  wdata,
  output mdm_ctl_t          ctl,
  output logic [BYTE_W-1:0] rdata,
  output logic              dtr_n,
  output logic              rts_n,
  output logic              out1_n,
  output logic              out2_n
);

  mdm_ctl_t ctl_q;
  mdm_ctl_t ctl_d;

  always_comb begin
    ctl_d = ctl_q;
    if (wr_en) ctl_d = mdm_ctl_t'(wdata);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctl_q <= '0;
    else        ctl_q <= ctl_d;
  end

  // Pins idle high in loopback, otherwise active-low copies.
  always_comb begin
    if (ctl_q.loop) begin
      dtr_n  = 1'b1;
      rts_n  = 1'b1;
      out1_n = 1'b1;
      out2_n = 1'b1;
    end else begin
      dtr_n  = ~ctl_q.dtr;
      rts_n  = ~ctl_q.rts;
      out1_n = ~ctl_q.out1;
      out2_n = ~ctl_q.out2;
    end
  end

  assign ctl   = ctl_q;
  assign rdata = {{(BYTE_W-CTL_W){1'b0}}, ctl_q};

endmodule

// File: rtl/modem_status.sv
`timescale 1ns/1ps
module modem_status
  import modem_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  mdm_lines_t        ext_lvl,
  input  mdm_ctl_t          ctl,
  input  logic              rd,
  output logic [BYTE_W-1:0] rdata,
  output logic              irq
);

  mdm_lines_t           lvl;
  mdm_lines_t           prev_q;
  mdm_lines_t           prev_d;
  logic [MDM_LINES-1:0] flag_q;
  logic [MDM_LINES-1:0] flag_d;
  logic [MDM_LINES-1:0] evt;

  always_comb begin
    lvl = ctl.loop ? loop_map(ctl) : ext_lvl;
  end

  // Change events: both edges for three lines, falling ring level only.
  always_comb begin
    evt[3] = prev_q.dcd ^ lvl.dcd;
    evt[2] = prev_q.ri & ~lvl.ri;
    evt[1] = prev_q.dsr ^ lvl.dsr;
    evt[0] = prev_q.cts ^ lvl.cts;
  end

  always_comb begin
    prev_d = lvl;
    flag_d = (rd ? '0 : flag_q) | evt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '0;
      flag_q <= '0;
    end else begin
      prev_q <= prev_d;
      flag_q <= flag_d;
    end
  end

  assign rdata = {lvl, flag_q};
  assign irq   = |flag_q;

endmodule

// File: rtl/modem_ctl_stat.sv
`timescale 1ns/1ps
module modem_ctl_stat
  import modem_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int RST_STAGES  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctl_wr,
  input  logic [BYTE_W-1:0] ctl_wdata,
  output logic [BYTE_W-1:0] ctl_rdata,
  input  logic              stat_rd,
  output logic [BYTE_W-1:0] stat_rdata,
  input  logic              cts_n,
  input  logic              dsr_n,
  input  logic              ri_n,
  input  logic              dcd_n,
  output logic              dtr_n,
  output logic              rts_n,
  output logic              out1_n,
  output logic              out2_n,
  output logic              irq
);

  logic                 rst_n_i;
  mdm_ctl_t             ctl;
  logic [MDM_LINES-1:0] pins_raw;
  logic [MDM_LINES-1:0] pins_sync;
  mdm_lines_t           ext_lvl;
  logic                 unused_hi;

  assign unused_hi = ^ctl_wdata[BYTE_W-1:CTL_W];

  modem_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_i)
  );

  modem_ctl_reg u_ctl (
    .clk    (clk),
    .rst_n  (rst_n_i),
    .wr_en  (ctl_wr),
    .wdata  (ctl_wdata[CTL_W-1:0]),
    .ctl    (ctl),
    .rdata  (ctl_rdata),
    .dtr_n  (dtr_n),
    .rts_n  (rts_n),
    .out1_n (out1_n),
    .out2_n (out2_n)
  );

  assign pins_raw = {dcd_n, ri_n, dsr_n, cts_n};

  modem_sync_bank #(
    .WIDTH   (MDM_LINES),
    .STAGES  (SYNC_STAGES),
    .RST_VAL (1'b1)
  ) u_sync (
    .clk   (clk),
    .rst_n (rst_n_i),
    .din   (pins_raw),
    .dout  (pins_sync)
  );

  assign ext_lvl = mdm_lines_t'(~pins_sync);

  modem_status u_stat (
    .clk     (clk),
    .rst_n   (rst_n_i),
    .ext_lvl (ext_lvl),
    .ctl     (ctl),
    .rd      (stat_rd),
    .rdata   (stat_rdata),
    .irq     (irq)
  );

endmodule

// File: rtl/modem_ctl_stat_chk.sv
`timescale 1ns/1ps
module modem_ctl_stat_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [7:0] ctl_rdata,
  input logic       stat_rd,
  input logic [7:0] stat_rdata,
  input logic       dtr_n,
  input logic       rts_n,
  input logic       out1_n,
  input logic       out2_n,
  input logic       irq
);

  // R2
  ctl_hi_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_rdata[7:5] == 3'b000);

  // R1
  pin_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_rdata[4] |-> ({out2_n, out1_n, rts_n, dtr_n} == ~ctl_rdata[3:0]));

  // R7
  loop_pins_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_rdata[4] |-> ({out2_n, out1_n, rts_n, dtr_n} == 4'b1111));

  // R8
  irq_or_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq == (stat_rdata[3:0] != 4'b0000));

  // R4
  flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !stat_rd |=> ((stat_rdata[3:0] & $past(stat_rdata[3:0])) == $past(stat_rdata[3:0])));

  // R5
  teri_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stat_rdata[2]) |-> ($past(stat_rdata[6], 2) && !$past(stat_rdata[6])));

endmodule

bind modem_ctl_stat modem_ctl_stat_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .ctl_rdata  (ctl_rdata),
  .stat_rd    (stat_rd),
  .stat_rdata (stat_rdata),
  .dtr_n      (dtr_n),
  .rts_n      (rts_n),
  .out1_n     (out1_n),
  .out2_n     (out2_n),
  .irq        (irq)
);

// File: tb/tb_modem_ctl_stat.sv
`timescale 1ns/1ps
module tb_modem_ctl_stat;

  localparam time CLK_P = 4ns;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       ctl_wr;
  logic [7:0] ctl_wdata;
  logic [7:0] ctl_rdata;
  logic       stat_rd;
  logic [7:0] stat_rdata;
  logic       cts_n, dsr_n, ri_n, dcd_n;
  logic       dtr_n, rts_n, out1_n, out2_n;
  logic       irq;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  logic [3:0] m_lvl;
  logic [3:0] m_flg;
  logic [4:0] m_ctl;

  always #(CLK_P/2) clk = ~clk;

  modem_ctl_stat dut (
    .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
    .ctl_rdata(ctl_rdata), .stat_rd(stat_rd), .stat_rdata(stat_rdata),
    .cts_n(cts_n), .dsr_n(dsr_n), .ri_n(ri_n), .dcd_n(dcd_n),
    .dtr_n(dtr_n), .rts_n(rts_n), .out1_n(out1_n), .out2_n(out2_n),
    .irq(irq)
  );

  task automatic check(input bit ok, input string req, input logic [7:0] act,
                       input logic [7:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // Bench model of one level transition.
  task automatic model_lvl(input logic [3:0] nl);
    m_flg[3] = m_flg[3] | (m_lvl[3] ^ nl[3]);
    m_flg[2] = m_flg[2] | (m_lvl[2] & ~nl[2]);
    m_flg[1] = m_flg[1] | (m_lvl[1] ^ nl[1]);
    m_flg[0] = m_flg[0] | (m_lvl[0] ^ nl[0]);
    m_lvl    = nl;
  endtask

  function automatic logic [3:0] loop_lvl(input logic [4:0] c);
    return {c[3], c[2], c[0], c[1]};
  endfunction

  function automatic logic [3:0] exp_lvl(input logic [3:0] pins, input logic [4:0] c);
    return c[4] ? loop_lvl(c) : ~pins;
  endfunction

  task automatic settle();
    repeat (3) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check_stat(input string req);
    check(stat_rdata == {m_lvl, m_flg}, req, stat_rdata, {m_lvl, m_flg});
    check(irq == (m_flg != 0), "R8", {7'd0, irq}, {7'd0, (m_flg != 0)});
  endtask

  task automatic write_ctl(input logic [7:0] v);
    @(negedge clk);
    ctl_wr = 1'b1; ctl_wdata = v;
    @(posedge clk);
    @(negedge clk);
    ctl_wr = 1'b0;
    m_ctl = v[4:0];
  endtask

  task automatic read_stat(input string req);
    @(negedge clk);
    stat_rd = 1'b1;
    check_stat(req);
    @(posedge clk);
    @(negedge clk);
    stat_rd = 1'b0;
    m_flg = 4'd0;
    check(stat_rdata[3:0] == 4'd0, "R6", stat_rdata, {m_lvl, 4'd0});
  endtask

  function automatic logic [3:0] pins_now();
    return {dcd_n, ri_n, dsr_n, cts_n};
  endfunction

  task automatic set_pins(input logic [3:0] p);
    {dcd_n, ri_n, dsr_n, cts_n} = p;
  endtask

  initial begin
    #(CLK_P * 150000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; ctl_wr = 1'b0; ctl_wdata = 8'h00; stat_rd = 1'b0;
    set_pins(4'hF);
    m_lvl = 4'd0; m_flg = 4'd0; m_ctl = 5'd0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R9 reset state, checked while reset is held
    check({out2_n, out1_n, rts_n, dtr_n} == 4'hF, "R9", {4'd0, out2_n, out1_n, rts_n, dtr_n}, 8'h0F);
    check(ctl_rdata == 8'h00, "R9", ctl_rdata, 8'h00);
    check(stat_rdata == 8'h00, "R9", stat_rdata, 8'h00);
    rst_n = 1'b1;
    repeat (5) @(posedge clk);
    @(negedge clk);
    check_stat("R9");

    // R1 R2 R7: every control byte value, readback and pins
    for (int v = 0; v < 256; v++) begin
      write_ctl(v[7:0]);
      check(ctl_rdata == {3'b000, v[4:0]}, "R2", ctl_rdata, {3'b000, v[4:0]});
      if (v[4])
        check({out2_n, out1_n, rts_n, dtr_n} == 4'hF, "R7",
              {4'd0, out2_n, out1_n, rts_n, dtr_n}, 8'h0F);
      else
        check({out2_n, out1_n, rts_n, dtr_n} == ~v[3:0], "R1",
              {4'd0, out2_n, out1_n, rts_n, dtr_n}, {4'd0, ~v[3:0]});
    end
    write_ctl(8'h00);
    settle();
    m_lvl = 4'd0; m_flg = 4'd0;
    @(negedge clk); stat_rd = 1'b1;
    @(posedge clk); @(negedge clk); stat_rd = 1'b0;
    check_stat("R6");

    // R3 R4: pin sweep, flags accumulate across unread steps
    for (int i = 0; i < 48; i++) begin
      logic [3:0] p;
      p = 4'((i * 7 + 3) ^ (i >> 2));
      @(negedge clk);
      set_pins(p);
      model_lvl(exp_lvl(p, m_ctl));
      settle();
      check_stat("R3 R4");
      if (i % 3 == 2) read_stat("R6");
    end
    read_stat("R6");

    // R3 level latency: not visible after one edge, visible after two
    @(negedge clk);
    set_pins(pins_now() ^ 4'b0001);
    @(posedge clk); @(negedge clk);
    check(stat_rdata[4] == m_lvl[0], "R3", stat_rdata, {m_lvl, m_flg});
    @(posedge clk); @(negedge clk);
    model_lvl(~pins_now());
    check(stat_rdata[7:4] == m_lvl, "R3", stat_rdata, {m_lvl, m_flg});
    settle();
    read_stat("R4");

    // R5: ring pin high->low leaves bit 2 clear, low->high sets it
    @(negedge clk); ri_n = 1'b1; settle(); model_lvl(~pins_now());
    read_stat("R5");
    @(negedge clk); ri_n = 1'b0; model_lvl(~pins_now()); settle();
    check(stat_rdata[2] == 1'b0, "R5", stat_rdata, {m_lvl, m_flg});
    @(negedge clk); ri_n = 1'b1; model_lvl(~pins_now()); settle();
    check(stat_rdata[2] == 1'b1, "R5", stat_rdata, {m_lvl, m_flg});
    read_stat("R5");

    // R6: read and new change land on the same edge
    @(negedge clk); cts_n = ~cts_n; model_lvl(~pins_now()); settle();
    check(stat_rdata[3:0] == 4'b0001, "R6", stat_rdata, {m_lvl, 4'b0001});
    @(negedge clk); dsr_n = ~dsr_n;
    @(posedge clk); @(posedge clk);
    @(negedge clk); stat_rd = 1'b1;
    check(stat_rdata[3:0] == 4'b0001, "R6", stat_rdata, {m_lvl, 4'b0001});
    @(posedge clk); @(negedge clk); stat_rd = 1'b0;
    m_flg = 4'd0; model_lvl(~pins_now());
    check(stat_rdata == {m_lvl, 4'b0010}, "R6", stat_rdata, {m_lvl, 4'b0010});
    check(irq == 1'b1, "R8", {7'd0, irq}, 8'h01);
    read_stat("R6");

    // R7: loopback sweep, external pins toggled and ignored
    for (int j = 0; j < 40; j++) begin
      logic [4:0] c;
      c = {1'b1, 4'((j * 5 + 1) ^ (j >> 1))};
      @(negedge clk);
      set_pins(4'(j ^ 9));
      write_ctl({3'b101, c});
      model_lvl(exp_lvl(pins_now(), c));
      settle();
      check_stat("R7");
      check({out2_n, out1_n, rts_n, dtr_n} == 4'hF, "R7",
            {4'd0, out2_n, out1_n, rts_n, dtr_n}, 8'h0F);
      if (j % 2 == 1) read_stat("R6");
    end

    // Leave loopback: levels return to the synchronised pins
    write_ctl(8'h00);
    model_lvl(exp_lvl(pins_now(), 5'd0));
    settle();
    check_stat("R7");
    read_stat("R6");

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule